// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits in front of one processor and decides which interrupt that processor is told about. It keeps a 32-bit pending-interrupt word, a processor priority threshold and a priority for inter-processor interrupts. It drives a single interrupt line. A source unit offers interrupts as a source number plus a priority. The block answers each offer in the same cycle, taking it or refusing it. When a more favoured offer displaces a pending interrupt, the displaced source number is handed back on a one-cycle reject strobe.

The processor side issues single-cycle commands:

- accept: read and acknowledge.
- poll: read without side effects.
- threshold write.
- inter-processor priority write.
- end-of-interrupt.

End-of-interrupt and resend requests leave the block as one-cycle strobes.

The pending word is always readable on `xirr_rd`. Bits 31:24 hold the threshold and bits 23:0 hold the pending source number. A source number of zero means nothing is pending. Priorities compare numerically, and a lower value is more favoured. 0xFF is the least favoured value.

Top module: `irq_present_ctrl`

## Requirements
- R1: After reset `xirr_rd` is 0x00000000, `mfrr_rd` is 0xFF, `irq_out` is low and no strobe is active; the internal pending priority is 0xFF, so an accept issued right after reset leaves `xirr_rd` at 0xFF000000.
- R2: An offer whose priority is greater than or equal to the threshold (`xirr_rd[31:24]`) is refused (`offer_taken` low) and changes no state.
- R3: An offer is refused when an interrupt is already pending at a priority less than or equal to the offer's priority.
- R4: A taken offer sets `xirr_rd[23:0]` to the offered source number and raises `irq_out` one clock later. If an offered source was pending, its number appears on `rej_src` with `rej_valid` high for one cycle.
- R5: Accept (`cmd_op`=0) lowers `irq_out`. It sets `xirr_rd` to {pending priority, 24'h0} and resets the pending priority to 0xFF.
- R6: Poll (`cmd_op`=1) leaves every output and all state unchanged.
- R7: Threshold write (`cmd_op`=2, value in `cmd_data[7:0]`) to a lower value clears a pending interrupt whose priority is not below the new threshold. The clear zeroes the source number and lowers `irq_out`, and a cleared offered source is rejected. A pending interrupt more favoured than the new threshold is kept.
- R8: A threshold write of an equal or higher value pulses `resend_req` when nothing is pending, and has no other effect while something is pending.
- R9: Inter-processor priority write (`cmd_op`=3, value in `cmd_data[7:0]`) updates `mfrr_rd`. When the value is below the threshold, an inter-processor interrupt is checked. It is made pending unless a pending interrupt is at least as favoured. When made pending, the source number becomes `IPI_SRC` (default 2), the pending priority becomes the written value and `irq_out` rises. The inter-processor interrupt is never sent out on the reject strobe, whether it displaces or is displaced.
- R10: End-of-interrupt (`cmd_op`=4) copies `cmd_data[31:24]` into the threshold and pulses `eoi_valid` with `eoi_src`=`cmd_data[23:0]`. If nothing is pending it also pulses `resend_req` and repeats the inter-processor check against the new threshold.
- R11: Commands take precedence over offers: an offer in a cycle with `cmd_valid` high is refused and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 accept, 1 poll, 2 threshold, 3 inter-processor priority, 4 end-of-interrupt) |
| cmd_data | input | 32 | Command operand |
| offer_valid | input | 1 | Offer present this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_taken | output | 1 | Same-cycle answer: offer taken |
| xirr_rd | output | 32 | Pending-interrupt word {threshold, source number} |
| mfrr_rd | output | 8 | Inter-processor priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject strobe |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_src | output | 24 | Source number of the end-of-interrupt |
| resend_req | output | 1 | Resend request strobe |

## Verification
`offer_taken` is combinational, so it is due in the same cycle as the offer. The bench samples it shortly after driving inputs on the falling edge. All other results pass through a single register and are due right after the next rising edge; `xirr_rd`, `mfrr_rd` and `irq_out` are then held, while the strobes last that one cycle only. Each table row is applied for exactly one clock, and all its expectations are read just after the edge that follows it. A strobe is therefore checked in its only valid cycle, and a missing or extra pulse is caught.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam int OP_W   = 3;

    localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};

    typedef enum logic [OP_W-1:0] {
        OP_ACCEPT   = 3'd0,
        OP_POLL     = 3'd1,
        OP_SET_CPPR = 3'd2,
        OP_SET_MFRR = 3'd3,
        OP_EOI      = 3'd4
    } irqp_op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  xisr;
        logic [PRIO_W-1:0] pprio;
        logic              owned;
        logic [PRIO_W-1:0] mfrr;
        logic              irq;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_src;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_src;
        logic              resend;
    } irqp_state_t;

    localparam irqp_state_t IRQP_RESET = '{
        cppr: '0, xisr: '0, pprio: PRIO_NONE, owned: 1'b0,
        mfrr: PRIO_NONE, irq: 1'b0, rej_v: 1'b0, rej_src: '0,
        eoi_v: 1'b0, eoi_src: '0, resend: 1'b0
    };
endpackage

// File: rtl/irqp_offer_judge.sv
module irqp_offer_judge
    import irqp_pkg::*;
(
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [PRIO_W-1:0] cppr,
    input  logic              busy,
    input  logic [PRIO_W-1:0] pprio,
    output logic              take
);
    always_comb begin
        take = 1'b1;
        if (offer_prio >= cppr) begin
            take = 1'b0;
        end else if (busy && (pprio <= offer_prio)) begin
            take = 1'b0;
        end
    end
endmodule

// File: rtl/irqp_ipi_check.sv
module irqp_ipi_check
    import irqp_pkg::*;
(
    input  logic [PRIO_W-1:0] chk_mfrr,
    input  logic [PRIO_W-1:0] chk_cppr,
    input  logic              busy,
    input  logic [PRIO_W-1:0] pprio,
    output logic              fire
);
    logic gate_open;
    logic held_off;

    always_comb begin
        gate_open = chk_mfrr < chk_cppr;
        held_off  = busy && (pprio <= chk_mfrr);
        fire      = gate_open && !held_off;
    end
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
    import irqp_pkg::*;
#(
    parameter int IPI_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              offer_taken,
    output logic [WORD_W-1:0] xirr_rd,
    output logic [PRIO_W-1:0] mfrr_rd,
    output logic              irq_out,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_req
);
    localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

    irqp_state_t q, d;

    logic              busy_q;
    logic              judge_take;
    logic              ipi_fire;
    logic [PRIO_W-1:0] cmd_byte;
    logic [PRIO_W-1:0] eoi_cppr;
    logic [PRIO_W-1:0] chk_mfrr;
    logic [PRIO_W-1:0] chk_cppr;

    assign busy_q   = q.xisr != '0;
    assign cmd_byte = cmd_data[PRIO_W-1:0];
    assign eoi_cppr = cmd_data[WORD_W-1:SRC_W];

    // The inter-processor check compares the new priority against the
    // current threshold, or the current priority against a new threshold.
    always_comb begin
        if (cmd_op == OP_SET_MFRR) begin
            chk_mfrr = cmd_byte;
            chk_cppr = q.cppr;
        end else if (cmd_op == OP_SET_CPPR) begin
            chk_mfrr = q.mfrr;
            chk_cppr = cmd_byte;
        end else begin
            chk_mfrr = q.mfrr;
            chk_cppr = eoi_cppr;
        end
    end

    irqp_offer_judge u_judge (
        .offer_prio (offer_prio),
        .cppr       (q.cppr),
        .busy       (busy_q),
        .pprio      (q.pprio),
        .take       (judge_take)
    );

    irqp_ipi_check u_ipi (
        .chk_mfrr (chk_mfrr),
        .chk_cppr (chk_cppr),
        .busy     (busy_q),
        .pprio    (q.pprio),
        .fire     (ipi_fire)
    );

    function automatic irqp_state_t load_ipi(irqp_state_t cur, irqp_state_t nxt,
                                             logic [PRIO_W-1:0] prio);
        irqp_state_t r;
        r = nxt;
        if ((cur.xisr != '0) && cur.owned) begin
            r.rej_v   = 1'b1;
            r.rej_src = cur.xisr;
        end
        r.xisr  = IPI_NUM;
        r.pprio = prio;
        r.owned = 1'b0;
        r.irq   = 1'b1;
        return r;
    endfunction

    always_comb begin
        d           = q;
        d.rej_v     = 1'b0;
        d.eoi_v     = 1'b0;
        d.resend    = 1'b0;
        offer_taken = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_ACCEPT: begin
                    d.irq   = 1'b0;
                    d.cppr  = q.pprio;
                    d.xisr  = '0;
                    d.pprio = PRIO_NONE;
                    d.owned = 1'b0;
                end
                OP_SET_CPPR: begin
                    d.cppr = cmd_byte;
                    if (cmd_byte < q.cppr) begin
                        if (busy_q && (cmd_byte <= q.pprio)) begin
                            d.xisr  = '0;
                            d.pprio = PRIO_NONE;
                            d.irq   = 1'b0;
                            d.owned = 1'b0;
                            if (q.owned) begin
                                d.rej_v   = 1'b1;
                                d.rej_src = q.xisr;
                            end
                        end
                    end else if (!busy_q) begin
                        d.resend = 1'b1;
                        if (ipi_fire) begin
                            d = load_ipi(q, d, chk_mfrr);
                        end
                    end
                end
                OP_SET_MFRR: begin
                    d.mfrr = cmd_byte;
                    if (ipi_fire) begin
                        d = load_ipi(q, d, chk_mfrr);
                    end
                end
                OP_EOI: begin
                    d.cppr    = eoi_cppr;
                    d.eoi_v   = 1'b1;
                    d.eoi_src = cmd_data[SRC_W-1:0];
                    if (!busy_q) begin
                        d.resend = 1'b1;
                        if (ipi_fire) begin
                            d = load_ipi(q, d, chk_mfrr);
                        end
                    end
                end
                default: begin
                end
            endcase
        end else if (offer_valid) begin
            offer_taken = judge_take;
            if (judge_take) begin
                if (busy_q && q.owned) begin
                    d.rej_v   = 1'b1;
                    d.rej_src = q.xisr;
                end
                d.xisr  = offer_src;
                d.owned = 1'b1;
                d.pprio = offer_prio;
                d.irq   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= IRQP_RESET;
        end else begin
            q <= d;
        end
    end

    assign xirr_rd    = {q.cppr, q.xisr};
    assign mfrr_rd    = q.mfrr;
    assign irq_out    = q.irq;
    assign rej_valid  = q.rej_v;
    assign rej_src    = q.rej_src;
    assign eoi_valid  = q.eoi_v;
    assign eoi_src    = q.eoi_src;
    assign resend_req = q.resend;

    assert_line_tracks_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (xirr_rd[SRC_W-1:0] != '0));

    assert_idle_prio_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.xisr == '0) |-> (q.pprio == PRIO_NONE));

    assert_offer_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        offer_taken |=> (xirr_rd[SRC_W-1:0] == $past(offer_src)) && irq_out);

    assert_offer_below_cppr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        offer_taken |-> (offer_prio < xirr_rd[WORD_W-1:SRC_W]));

    assert_cmd_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !offer_taken);

    assert_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACCEPT) |=> (xirr_rd[SRC_W-1:0] == '0) && !irq_out);

    assert_ipi_not_rejected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (rej_src != IPI_NUM));
endmodule

// File: tb/sim_irq_present_ctrl.sv
module sim_irq_present_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] cmd_data = 32'h0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = 24'h0;
    logic [7:0]  offer_prio = 8'h0;
    logic        offer_taken;
    logic [31:0] xirr_rd;
    logic [7:0]  mfrr_rd;
    logic        irq_out;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_present_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .offer_valid(offer_valid), .offer_src(offer_src),
        .offer_prio(offer_prio), .offer_taken(offer_taken), .xirr_rd(xirr_rd),
        .mfrr_rd(mfrr_rd), .irq_out(irq_out), .rej_valid(rej_valid),
        .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_req(resend_req)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        cv;
        logic [2:0]  op;
        logic [31:0] data;
        logic        ov;
        logic [23:0] src;
        logic [7:0]  prio;
        logic        taken;
        logic [31:0] xirr;
        logic [7:0]  mfrr;
        logic        irq;
        logic        rv;
        logic [23:0] rsrc;
        logic        ev;
        logic [23:0] esrc;
        logic        rs;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{"R2 ",1'b0,3'd0,32'h0,       1'b1,24'h10,8'h05, 1'b0,32'h00000000,8'hFF,1'b0,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R8 ",1'b1,3'd2,32'hFF,      1'b0,24'h0, 8'h00, 1'b0,32'hFF000000,8'hFF,1'b0,1'b0,24'h0, 1'b0,24'h0, 1'b1},
        '{"R4 ",1'b0,3'd0,32'h0,       1'b1,24'h10,8'h05, 1'b1,32'hFF000010,8'hFF,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R3 ",1'b0,3'd0,32'h0,       1'b1,24'h20,8'h05, 1'b0,32'hFF000010,8'hFF,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R4 ",1'b0,3'd0,32'h0,       1'b1,24'h20,8'h03, 1'b1,32'hFF000020,8'hFF,1'b1,1'b1,24'h10,1'b0,24'h0, 1'b0},
        '{"R6 ",1'b1,3'd1,32'h0,       1'b0,24'h0, 8'h00, 1'b0,32'hFF000020,8'hFF,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R5 ",1'b1,3'd0,32'h0,       1'b0,24'h0, 8'h00, 1'b0,32'h03000000,8'hFF,1'b0,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R10",1'b1,3'd4,32'hFF000020,1'b0,24'h0, 8'h00, 1'b0,32'hFF000000,8'hFF,1'b0,1'b0,24'h0, 1'b1,24'h20,1'b1},
        '{"R9 ",1'b1,3'd3,32'h04,      1'b0,24'h0, 8'h00, 1'b0,32'hFF000002,8'h04,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R9 ",1'b0,3'd0,32'h0,       1'b1,24'h30,8'h02, 1'b1,32'hFF000030,8'h04,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R7 ",1'b1,3'd2,32'h02,      1'b0,24'h0, 8'h00, 1'b0,32'h02000000,8'h04,1'b0,1'b1,24'h30,1'b0,24'h0, 1'b0},
        '{"R11",1'b1,3'd1,32'h0,       1'b1,24'h40,8'h01, 1'b0,32'h02000000,8'h04,1'b0,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R9 ",1'b1,3'd3,32'h01,      1'b0,24'h0, 8'h00, 1'b0,32'h02000002,8'h01,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R4 ",1'b0,3'd0,32'h0,       1'b1,24'h50,8'h00, 1'b1,32'h02000050,8'h01,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R9 ",1'b1,3'd3,32'h03,      1'b0,24'h0, 8'h00, 1'b0,32'h02000050,8'h03,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R5 ",1'b1,3'd0,32'h0,       1'b0,24'h0, 8'h00, 1'b0,32'h00000000,8'h03,1'b0,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R10",1'b1,3'd4,32'h05000050,1'b0,24'h0, 8'h00, 1'b0,32'h05000002,8'h03,1'b1,1'b0,24'h0, 1'b1,24'h50,1'b1},
        '{"R9 ",1'b1,3'd3,32'h02,      1'b0,24'h0, 8'h00, 1'b0,32'h05000002,8'h02,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R3 ",1'b0,3'd0,32'h0,       1'b1,24'h60,8'h02, 1'b0,32'h05000002,8'h02,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R8 ",1'b1,3'd2,32'h06,      1'b0,24'h0, 8'h00, 1'b0,32'h06000002,8'h02,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R7 ",1'b1,3'd2,32'h04,      1'b0,24'h0, 8'h00, 1'b0,32'h04000002,8'h02,1'b1,1'b0,24'h0, 1'b0,24'h0, 1'b0},
        '{"R7 ",1'b1,3'd2,32'h02,      1'b0,24'h0, 8'h00, 1'b0,32'h02000000,8'h02,1'b0,1'b0,24'h0, 1'b0,24'h0, 1'b0}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_valid   = 1'b0;
        cmd_op      = 3'd0;
        cmd_data    = 32'h0;
        offer_valid = 1'b0;
        offer_src   = 24'h0;
        offer_prio  = 8'h0;
    endtask

    task automatic check_rest(input string tag);
        check(tag, "xirr", xirr_rd, 32'h0);
        check(tag, "mfrr", {24'h0, mfrr_rd}, 32'hFF);
        check(tag, "irq", {31'h0, irq_out}, 32'h0);
        check(tag, "strobes", {29'h0, rej_valid, eoi_valid, resend_req}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        string t;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_rest("R1");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            t           = string'(VECS[i].tag);
            cmd_valid   = VECS[i].cv;
            cmd_op      = VECS[i].op;
            cmd_data    = VECS[i].data;
            offer_valid = VECS[i].ov;
            offer_src   = VECS[i].src;
            offer_prio  = VECS[i].prio;
            #1;
            check(t, "offer_taken", {31'h0, offer_taken}, {31'h0, VECS[i].taken});
            @(posedge clk);
            #1;
            check(t, "xirr", xirr_rd, VECS[i].xirr);
            check(t, "mfrr", {24'h0, mfrr_rd}, {24'h0, VECS[i].mfrr});
            check(t, "irq", {31'h0, irq_out}, {31'h0, VECS[i].irq});
            check(t, "rej_valid", {31'h0, rej_valid}, {31'h0, VECS[i].rv});
            if (VECS[i].rv) check(t, "rej_src", {8'h0, rej_src}, {8'h0, VECS[i].rsrc});
            check(t, "eoi_valid", {31'h0, eoi_valid}, {31'h0, VECS[i].ev});
            if (VECS[i].ev) check(t, "eoi_src", {8'h0, eoi_src}, {8'h0, VECS[i].esrc});
            check(t, "resend", {31'h0, resend_req}, {31'h0, VECS[i].rs});
            @(negedge clk);
            idle_inputs();
        end

        // R1: reset from a busy state, then accept exposes pending priority 0xFF
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_data = 32'h01;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_rest("R1");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0;
        @(posedge clk);
        #1;
        check("R1", "xirr after accept", xirr_rd, 32'hFF000000);
        check("R1", "irq after accept", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        idle_inputs();

        // R2: offer at priority equal to the threshold is refused
        @(negedge clk);
        offer_valid = 1'b1; offer_src = 24'h77; offer_prio = 8'hFF;
        #1;
        check("R2", "offer_taken at equal", {31'h0, offer_taken}, 32'h0);
        @(posedge clk);
        #1;
        check("R2", "xirr unchanged", xirr_rd, 32'hFF000000);
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        finish_run();
    end
endmodule